// File: doc/BRIEF.md
# Closed Caption Line Encoder

This block produces the digital level stream for the caption data line of an NTSC picture. The host stores two 7-bit characters for each of the two caption lines (line 21 in the first field, line 284 in the second). On a matching line, and only when that line is enabled, the block emits a fixed waveform. It begins at a set horizontal offset from the leading edge of horizontal sync. First comes a clock run-in of seven bit periods. Then come three start bits. Last come the two characters, each sent least significant bit first and each followed by a parity bit. The output is a 10-bit level that the luma path sums in; outside the waveform it sits at the blanking code.

Host writes land in front-end registers. A rising edge on VSYNC copies all four front registers into the rear-end buffers, and the line waveform is always built from the rear buffers. When the optional auto-clear is set, the same VSYNC edge also zeroes the front registers. The characters therefore go out once, and the following field carries nulls unless the host writes again.

Top module: `cc_line_encoder`

## Requirements
- R1: After reset the output is the blanking code (256), and all front and rear characters are 0, so a first enabled line carries two null characters.
- R2: With cc_mode bit 0 set, line 21 carries the waveform built from the line-21 characters (write addresses 0 = first character, 1 = second character).
- R3: With cc_mode bit 1 set, line 284 carries the waveform built from the line-284 characters (write addresses 2 = first character, 3 = second character).
- R4: A caption line whose cc_mode bit is clear outputs only the blanking code for the whole line; cc_mode 00 disables both lines.
- R5: The waveform starts one sample after hpos equals START_POS and spans 26 bit periods of 4*QTR_CYC samples each. The first 7 periods form the run-in, and each run-in period steps mid, high, mid, blank over its four quarters. The mid level is (blank+high)/2.
- R6: Bit periods 7 to 25 carry, in order: start bits 0, 0, 1; first character bits 0 to 6; its parity; second character bits 0 to 6; its parity. Each parity bit makes its 8-bit group odd. A 1 is the high level and a 0 is blank.
- R7: The high level is 50 IRE above blanking, code 531. Blank is code 256. The output never holds any value other than blank, mid or high.
- R8: A host write changes only the front register; the transmitted characters change only after the next rising edge of vsync.
- R9: With auto_clr at 0, repeated vsync edges keep transmitting the last characters written.
- R10: With auto_clr at 1, a vsync rising edge copies the front registers to the rear and then clears the front registers to 0, so the next field sends null characters unless rewritten.
- R11: Before START_POS, after the 26th bit period, and on any line other than 21 and 284, the output is the blanking code.
- R12: A write in the same cycle as a vsync rising edge is stored in the front register, while the rear buffer takes the value the front held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_num | input | 10 | Current frame line number |
| hpos | input | 11 | Sample position within the line, 0 at the sync leading edge |
| vsync | input | 1 | Vertical sync; the rising edge transfers front to rear |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Character select: 0/1 line 21, 2/3 line 284 |
| wr_data | input | 7 | Character written |
| cc_mode | input | 2 | Bit 0 enables line 21, bit 1 enables line 284 |
| auto_clr | input | 1 | Clear the front registers on each vsync transfer |
| level_out | output | 10 | Caption level sample |

## Verification
A corrupted rear buffer or a wrong front-to-rear transfer is visible as a single wrong bit period. The error shows on the next enabled caption line, at the first character bit that differs, and within a field of the faulty VSYNC edge. A sequencer that slips a quarter or a slot shows up as a misplaced run-in step within the first bit period of the waveform. A sequencer that fails to stop shows up as non-blank samples after the 26th period. Every caption line is compared sample by sample against a model built from the requirements, so either failure is reported on the line where it first appears.

// File: rtl/cc_line_encoder.sv
`timescale 1ns/1ps
module cc_line_encoder #(
  parameter int LINE_W    = 10,
  parameter int HPOS_W    = 11,
  parameter int LVL_W     = 10,
  parameter int LINE_A    = 21,
  parameter int LINE_B    = 284,
  parameter int START_POS = 284,
  parameter int QTR_CYC   = 13,
  parameter int BLANK_LVL = 256,
  parameter int HIGH_LVL  = 531
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic [HPOS_W-1:0] hpos,
  input  logic              vsync,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [6:0]        wr_data,
  input  logic [1:0]        cc_mode,
  input  logic              auto_clr,
  output logic [LVL_W-1:0]  level_out
);
  localparam int CW     = 7;
  localparam int NCHAR  = 4;
  localparam int RUNIN  = 7;
  localparam int FBITS  = 2 * (CW + 1) + 3;
  localparam int SLOTS  = RUNIN + FBITS;
  localparam int SW     = $clog2(SLOTS);
  localparam int QW     = $clog2(QTR_CYC + 1);
  localparam logic [LVL_W-1:0] LV_BLANK = LVL_W'(BLANK_LVL);
  localparam logic [LVL_W-1:0] LV_HIGH  = LVL_W'(HIGH_LVL);
  localparam logic [LVL_W-1:0] LV_MID   = LVL_W'((BLANK_LVL + HIGH_LVL) / 2);

  logic [NCHAR*CW-1:0] front, rear;
  logic                vs_d, active, on_b;
  logic [SW-1:0]       slot;
  logic [1:0]          qidx;
  logic [QW-1:0]       qcnt;

  wire vs_rise = vsync & ~vs_d;
  wire hit_a   = (line_num == LINE_W'(LINE_A)) && cc_mode[0];
  wire hit_b   = (line_num == LINE_W'(LINE_B)) && cc_mode[1];
  wire launch  = !active && (hpos == HPOS_W'(START_POS)) && (hit_a || hit_b);
  wire q_end   = (qcnt == QW'(QTR_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      front <= '0;
      rear  <= '0;
      vs_d  <= 1'b0;
    end else begin
      vs_d <= vsync;
      if (vs_rise) begin
        rear <= front;
        if (auto_clr) front <= '0;
      end
      if (wr_en) front[int'(wr_addr)*CW +: CW] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      on_b   <= 1'b0;
      slot   <= '0;
      qidx   <= '0;
      qcnt   <= '0;
    end else if (launch) begin
      active <= 1'b1;
      on_b   <= hit_b;
      slot   <= '0;
      qidx   <= '0;
      qcnt   <= '0;
    end else if (active) begin
      if (!q_end) begin
        qcnt <= qcnt + 1'b1;
      end else begin
        qcnt <= '0;
        qidx <= qidx + 1'b1;
        if (qidx == 2'd3) begin
          if (slot == SW'(SLOTS - 1)) active <= 1'b0;
          else slot <= slot + 1'b1;
        end
      end
    end
  end

  wire [CW-1:0]    c1    = on_b ? rear[2*CW +: CW] : rear[0 +: CW];
  wire [CW-1:0]    c2    = on_b ? rear[3*CW +: CW] : rear[CW +: CW];
  wire [FBITS-1:0] frame = {~^c2, c2, ~^c1, c1, 3'b100};
  wire [SW-1:0]    fidx  = slot - SW'(RUNIN);

  always_comb begin
    if (!active)
      level_out = LV_BLANK;
    else if (slot < SW'(RUNIN))
      case (qidx)
        2'd1:    level_out = LV_HIGH;
        2'd3:    level_out = LV_BLANK;
        default: level_out = LV_MID;
      endcase
    else
      level_out = frame[fidx] ? LV_HIGH : LV_BLANK;
  end

  // R8
  rear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vsync && !vs_d) |=> $stable(rear));
  // R9
  front_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !vs_d && !auto_clr && !wr_en) |=> $stable(front));
  // R10
  front_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !vs_d && auto_clr && !wr_en) |=> (front == '0));
  // R4
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_mode == 2'b00 && !active) |=> !active);
  // R11
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (slot < SW'(SLOTS)));
  // R7
  level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_out == LV_BLANK) || (level_out == LV_MID) || (level_out == LV_HIGH));
endmodule

// File: tb/sim_cc_line_encoder.sv
`timescale 1ns/1ps
module sim_cc_line_encoder;
  localparam int START = 10;
  localparam int QTR   = 2;
  localparam int BITP  = 4 * QTR;
  localparam int SPAN  = 26 * BITP;
  localparam int LLEN  = 240;
  localparam int BLK = 256, HI = 531, MID = (256 + 531) / 2;

  // {mode[1:0], line284, c1[6:0], c2[6:0]}
  localparam logic [16:0] VEC [7] = '{
    {2'b01, 1'b0, 7'h41, 7'h62},
    {2'b01, 1'b1, 7'h41, 7'h62},
    {2'b10, 1'b1, 7'h43, 7'h64},
    {2'b10, 1'b0, 7'h43, 7'h64},
    {2'b00, 1'b0, 7'h10, 7'h20},
    {2'b11, 1'b0, 7'h7f, 7'h00},
    {2'b11, 1'b1, 7'h55, 7'h2a}
  };

  logic clk = 0, rst_n = 0, vsync = 0, wr_en = 0, auto_clr = 0;
  logic [9:0] line_num = 0;
  logic [10:0] hpos = 0;
  logic [1:0] wr_addr = 0, cc_mode = 0;
  logic [6:0] wr_data = 0;
  logic [9:0] level_out;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cc_line_encoder #(.START_POS(START), .QTR_CYC(QTR)) u0 (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .hpos(hpos), .vsync(vsync),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cc_mode(cc_mode),
    .auto_clr(auto_clr), .level_out(level_out));

  function automatic int model(int n, logic [6:0] c1, logic [6:0] c2);
    logic [18:0] fr;
    int s, q;
    fr = {~^c2, c2, ~^c1, c1, 3'b100};
    s = n / BITP;
    q = (n % BITP) / QTR;
    if (s < 7) return (q == 1) ? HI : (q == 3) ? BLK : MID;
    return fr[s-7] ? HI : BLK;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [6:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic vpulse();
    vsync = 1; tick(); tick();
    vsync = 0; tick();
  endtask

  task automatic run_line(input int ln, input logic [6:0] c1, input logic [6:0] c2,
                          input bit en, input string tag);
    int bad_h, bad_a, bad_e;
    bit bad;
    bad = 0; bad_h = 0; bad_a = 0; bad_e = 0;
    line_num = 10'(ln);
    for (int h = 0; h < LLEN; h++) begin
      int e;
      hpos = 11'(h);
      tick();
      e = (en && h >= START && h - START < SPAN) ? model(h - START, c1, c2) : BLK;
      if (!bad && int'(level_out) != e) begin
        bad = 1; bad_h = h; bad_a = int'(level_out); bad_e = e;
      end
    end
    line_num = 0; hpos = 0;
    tick();
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s line %0d hpos %0d: got %0d expected %0d", tag, ln, bad_h, bad_a, bad_e);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    checks++;
    if (level_out !== 10'(BLK)) begin
      fails++; $display("FAIL R1 reset level: got %0d expected %0d", level_out, BLK);
    end
    vpulse(); cc_mode = 2'b11;
    run_line(21, 7'h00, 7'h00, 1, "R1");

    // R2 R3 R4 with R5 R6 R7 waveform content
    for (int i = 0; i < 7; i++) begin
      logic [1:0] m; logic b; logic [6:0] c1, c2; bit en;
      {m, b, c1, c2} = VEC[i];
      wr({b, 1'b0}, c1); wr({b, 1'b1}, c2);
      vpulse();
      cc_mode = m;
      en = b ? m[1] : m[0];
      run_line(b ? 284 : 21, c1, c2, en, en ? (b ? "R3/R5/R6/R7" : "R2/R5/R6/R7") : "R4");
    end

    cc_mode = 2'b01;
    wr(2'd0, 7'h31); wr(2'd1, 7'h32);
    run_line(21, 7'h7f, 7'h00, 1, "R8");
    vpulse();
    run_line(21, 7'h31, 7'h32, 1, "R8");

    vpulse(); vpulse();
    run_line(21, 7'h31, 7'h32, 1, "R9");

    auto_clr = 1;
    wr(2'd0, 7'h0a); wr(2'd1, 7'h0b);
    vpulse();
    run_line(21, 7'h0a, 7'h0b, 1, "R10");
    vpulse();
    run_line(21, 7'h00, 7'h00, 1, "R10");
    auto_clr = 0;

    wr_en = 1; wr_addr = 2'd0; wr_data = 7'h11; vsync = 1;
    tick();
    wr_en = 0; tick(); vsync = 0; tick();
    run_line(21, 7'h00, 7'h00, 1, "R12");
    vpulse();
    run_line(21, 7'h11, 7'h00, 1, "R12");

    cc_mode = 2'b11;
    run_line(20, 7'h00, 7'h00, 0, "R11");
    run_line(285, 7'h00, 7'h00, 0, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule